// File: doc/BRIEF.md
# Dual-Mode Integer Arithmetic Flag Unit

This block is the integer arithmetic slice of a 64-bit core that can also run 32-bit code. It takes two operands, an operation select and a handful of control bits. In the same cycle it returns a result. It also registers a small flag file: two carry flags, two overflow flags and a sticky summary-overflow flag.

The block keeps two sets of flags. The mode-dependent pair (CA, OV) follows the width the core is running at. The low-word pair (CA32, OV32) always describes the low 32-bit half of the computation. For multiply and divide, a separate size bit chooses between word and doubleword overflow, and the mode bit plays no part there.

All operations are combinational. Divide is behavioural and completes in the same cycle. The flag file updates on the rising clock edge when the operation strobe is high. A software flag write loads the whole flag file and takes priority over the strobe. A synchronous reset clears every flag.

Operation encoding on `op_sel`:

| Code | Operation |
|------|-----------|
| 0 | a+b |
| 1 | a+b+carry_in |
| 2 | ~a+b+1 |
| 3 | ~a+b+carry_in |
| 4 | negate a |
| 5 | low multiply |
| 6 | signed divide |
| 7 | no operation |

Flag bit positions on `flags` and `flag_wdata`:

| Bit | Flag |
|-----|------|
| 4 | SO |
| 3 | OV |
| 2 | OV32 |
| 1 | CA |
| 0 | CA32 |

The design has no state machine. Its only state is the flag register.

Top module: `dmf_unit`

## Requirements
- R1: For op_sel 0 to 3, result is the low 64 bits of x+b+c. x is src_a for codes 0 and 1 and ~src_a for codes 2 and 3. c is 0 for code 0, 1 for code 2, and carry_in for codes 1 and 3.
- R2: Codes 0 to 3 always update both carry flags. CA32 (bit 0) takes the carry out of bit 31. CA (bit 1) takes the carry out of bit 63 when wide_mode=1, and the carry out of bit 31 when wide_mode=0, so in that mode CA equals CA32.
- R3: For codes 0 to 3 with ov_enable=1, OV32 (bit 2) takes the signed overflow of the low 32-bit sum. OV (bit 3) takes the signed overflow of the 64-bit sum when wide_mode=1, and of the low 32-bit sum when wide_mode=0.
- R4: Code 4 returns 0-src_a. With ov_enable=1, OV and OV32 are both set when src_a equals 0x8000_0000_0000_0000 (wide_mode=1) or when src_a[31:0] equals 0x8000_0000 (wide_mode=0). Otherwise both are cleared.
- R5: Code 5 with dw_size=1 returns the low 64 bits of the signed product, and overflows when that product does not fit in 64 signed bits. With dw_size=0 it returns the 64-bit signed product of the low words, and overflows when that product does not fit in 32 signed bits. With ov_enable=1, OV and OV32 both take the overflow.
- R6: Code 6 returns the signed quotient truncated toward zero. With dw_size=1 it divides the full operands. With dw_size=0 it divides the low words and returns the 32-bit quotient sign-extended to 64 bits. A zero divisor, or the most negative dividend divided by -1, counts as overflow for the selected size and forces the result to 0. With ov_enable=1, OV and OV32 both take the overflow.
- R7: With ov_enable=0, OV, OV32 and SO keep their previous values.
- R8: SO (bit 4) is set whenever an operation with ov_enable=1 writes OV as 1. Only a flag write or a reset lowers it.
- R9: With op_valid=0, or with code 7, no flag changes; code 7 returns 0. Codes 4 to 6 leave CA and CA32 unchanged.
- R10: A synchronous reset (rst=1) clears all flags. flag_wr=1 loads flag_wdata into the flag file on the next edge, with priority over op_valid.
- R11: The flags are registered. During the cycle of an operation they still show the previous value, and they change only at the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe; enables the flag update |
| op_sel | input | 3 | Operation code |
| wide_mode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| dw_size | input | 1 | Multiply/divide size: 1 = doubleword, 0 = word |
| ov_enable | input | 1 | Allows the overflow flags to update |
| carry_in | input | 1 | Carry input for codes 1 and 3 |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| flag_wr | input | 1 | Software flag write |
| flag_wdata | input | 5 | Value loaded by a flag write |
| result | output | 64 | Combinational result |
| flags | output | 5 | Registered flags {SO,OV,OV32,CA,CA32} |

## Verification
The bench sweeps every operation against a set of boundary operands in both modes and both sizes, with overflow enabled and disabled. Before each operation it preloads a different flag value, which exposes any flag that an operation should not have touched.

The operand set was chosen to hit specific faults:
- Values near the 32-bit and 64-bit sign boundaries would reveal a carry or overflow taken from the wrong bit, or a mode-dependent flag that ignores the mode.
- The two overflow divides would return garbage or miss the overflow if they were not trapped.
- A word multiply whose high product half is nonzero would pass unnoticed if overflow were judged on 64 bits.

Directed sequences cover the remaining cases. A lost SO shows up as a cleared flag after a later clean operation. A flag write that loses its priority over the strobe is caught, and so is a flag path that is not registered, which would show the new value during the cycle of the operation.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADDC  = 3'd1,
        OP_RSUB  = 3'd2,
        OP_RSUBC = 3'd3,
        OP_NEG   = 3'd4,
        OP_MULLO = 3'd5,
        OP_DIV   = 3'd6,
        OP_NONE  = 3'd7
    } dmf_op_e;

    typedef struct packed {
        logic so;
        logic ov;
        logic ov32;
        logic ca;
        logic ca32;
    } dmf_flags_t;

    localparam int FLAG_BITS = $bits(dmf_flags_t);

endpackage

// File: rtl/dmf_addsub.sv
module dmf_addsub #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_a,
    input  logic         use_cin,
    input  logic         cin,
    input  logic         wide,
    output logic [W-1:0] sum,
    output logic         ca,
    output logic         ca32,
    output logic         ov,
    output logic         ov32
);
    localparam int H  = W / 2;
    localparam int HW = W - H;

    logic [W-1:0]  x;
    logic          c_eff;
    logic [H:0]    lo_sum;
    logic [HW:0]   hi_sum;
    logic          ovf_full;
    logic          ovf_low;

    // Split the carry chain at the half boundary so the low carry is a real net.
    always_comb begin
        x        = invert_a ? ~a : a;
        c_eff    = use_cin ? cin : invert_a;
        lo_sum   = {1'b0, x[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, c_eff};
        hi_sum   = {1'b0, x[W-1:H]} + {1'b0, b[W-1:H]} + {{HW{1'b0}}, lo_sum[H]};
        sum      = {hi_sum[HW-1:0], lo_sum[H-1:0]};
        ovf_low  = (x[H-1] == b[H-1]) && (sum[H-1] != x[H-1]);
        ovf_full = (x[W-1] == b[W-1]) && (sum[W-1] != x[W-1]);
        ca32     = lo_sum[H];
        ca       = wide ? hi_sum[HW] : lo_sum[H];
        ov32     = ovf_low;
        ov       = wide ? ovf_full : ovf_low;
    end

endmodule

// File: rtl/dmf_neg.sv
module dmf_neg #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic         wide,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int H = W / 2;
    localparam logic [W-1:0] MIN_D = {1'b1, {(W-1){1'b0}}};
    localparam logic [H-1:0] MIN_W = {1'b1, {(H-1){1'b0}}};

    always_comb begin
        res = ~a + {{(W-1){1'b0}}, 1'b1};
        ovf = wide ? (a == MIN_D) : (a[H-1:0] == MIN_W);
    end

endmodule

// File: rtl/dmf_muldiv.sv
module dmf_muldiv #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         dword,
    output logic [W-1:0] mul_res,
    output logic         mul_ovf,
    output logic [W-1:0] div_res,
    output logic         div_ovf
);
    localparam int H = W / 2;
    localparam logic [W-1:0] MIN_D = {1'b1, {(W-1){1'b0}}};
    localparam logic [H-1:0] MIN_W = {1'b1, {(H-1){1'b0}}};

    logic [2*W-1:0] pd;
    logic [W-1:0]   pw;
    logic           ovf_md, ovf_mw;

    logic           ovf_dd, ovf_dw;
    logic [W-1:0]   bd_safe;
    logic [H-1:0]   bw_safe;
    logic signed [W-1:0] qd;
    logic signed [H-1:0] qw;

    // Low multiply: sign-extend first so an unsigned product gives the signed bits.
    always_comb begin
        pd     = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
        pw     = {{H{a[H-1]}}, a[H-1:0]} * {{H{b[H-1]}}, b[H-1:0]};
        ovf_md = pd[2*W-1:W-1] != {(W+1){pd[W-1]}};
        ovf_mw = pw[W-1:H-1] != {(H+1){pw[H-1]}};
        mul_res = dword ? pd[W-1:0] : pw;
        mul_ovf = dword ? ovf_md : ovf_mw;
    end

    // Divide: trap the two overflow cases before the divider sees them.
    always_comb begin
        ovf_dd  = (b == '0) || ((a == MIN_D) && (b == '1));
        ovf_dw  = (b[H-1:0] == '0) || ((a[H-1:0] == MIN_W) && (b[H-1:0] == '1));
        bd_safe = ovf_dd ? {{(W-1){1'b0}}, 1'b1} : b;
        bw_safe = ovf_dw ? {{(H-1){1'b0}}, 1'b1} : b[H-1:0];
    end

    assign qd = $signed(a) / $signed(bd_safe);
    assign qw = $signed(a[H-1:0]) / $signed(bw_safe);

    always_comb begin
        if (dword) begin
            div_ovf = ovf_dd;
            div_res = ovf_dd ? '0 : qd;
        end else begin
            div_ovf = ovf_dw;
            div_res = ovf_dw ? '0 : {{H{qw[H-1]}}, qw};
        end
    end

endmodule

// File: rtl/dmf_flagreg.sv
module dmf_flagreg
    import dmf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       wr,
    input  dmf_flags_t wdata,
    input  logic       upd_ca,
    input  logic       ca_new,
    input  logic       ca32_new,
    input  logic       upd_ov,
    input  logic       ov_new,
    input  logic       ov32_new,
    output dmf_flags_t q
);
    dmf_flags_t nxt;

    always_comb begin
        nxt = q;
        if (wr) begin
            nxt = wdata;
        end else if (valid) begin
            if (upd_ca) begin
                nxt.ca   = ca_new;
                nxt.ca32 = ca32_new;
            end
            if (upd_ov) begin
                nxt.ov   = ov_new;
                nxt.ov32 = ov32_new;
                nxt.so   = q.so | ov_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/dmf_unit.sv
module dmf_unit
    import dmf_pkg::*;
#(
    parameter int W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic [2:0]           op_sel,
    input  logic                 wide_mode,
    input  logic                 dw_size,
    input  logic                 ov_enable,
    input  logic                 carry_in,
    input  logic [W-1:0]         src_a,
    input  logic [W-1:0]         src_b,
    input  logic                 flag_wr,
    input  logic [FLAG_BITS-1:0] flag_wdata,
    output logic [W-1:0]         result,
    output logic [FLAG_BITS-1:0] flags
);
    dmf_op_e      op;
    logic [W-1:0] as_sum, neg_res, mul_res, div_res;
    logic         as_ca, as_ca32, as_ov, as_ov32;
    logic         neg_ovf, mul_ovf, div_ovf;
    logic         ov_new, ov32_new, upd_ca, upd_ov;
    dmf_flags_t   fq;

    assign op = dmf_op_e'(op_sel);

    dmf_addsub #(.W(W)) u_addsub (
        .a        (src_a),
        .b        (src_b),
        .invert_a (op_sel[1]),
        .use_cin  (op_sel[0]),
        .cin      (carry_in),
        .wide     (wide_mode),
        .sum      (as_sum),
        .ca       (as_ca),
        .ca32     (as_ca32),
        .ov       (as_ov),
        .ov32     (as_ov32)
    );

    dmf_neg #(.W(W)) u_neg (
        .a    (src_a),
        .wide (wide_mode),
        .res  (neg_res),
        .ovf  (neg_ovf)
    );

    dmf_muldiv #(.W(W)) u_muldiv (
        .a       (src_a),
        .b       (src_b),
        .dword   (dw_size),
        .mul_res (mul_res),
        .mul_ovf (mul_ovf),
        .div_res (div_res),
        .div_ovf (div_ovf)
    );

    always_comb begin
        upd_ca = 1'b0;
        upd_ov = ov_enable;
        unique case (op)
            OP_ADD, OP_ADDC, OP_RSUB, OP_RSUBC: begin
                result   = as_sum;
                ov_new   = as_ov;
                ov32_new = as_ov32;
                upd_ca   = 1'b1;
            end
            OP_NEG: begin
                result   = neg_res;
                ov_new   = neg_ovf;
                ov32_new = neg_ovf;
            end
            OP_MULLO: begin
                result   = mul_res;
                ov_new   = mul_ovf;
                ov32_new = mul_ovf;
            end
            OP_DIV: begin
                result   = div_res;
                ov_new   = div_ovf;
                ov32_new = div_ovf;
            end
            OP_NONE: begin
                result   = '0;
                ov_new   = 1'b0;
                ov32_new = 1'b0;
                upd_ov   = 1'b0;
            end
        endcase
    end

    dmf_flagreg u_flags (
        .clk      (clk),
        .rst      (rst),
        .valid    (op_valid),
        .wr       (flag_wr),
        .wdata    (dmf_flags_t'(flag_wdata)),
        .upd_ca   (upd_ca),
        .ca_new   (as_ca),
        .ca32_new (as_ca32),
        .upd_ov   (upd_ov),
        .ov_new   (ov_new),
        .ov32_new (ov32_new),
        .q        (fq)
    );

    assign flags = fq;

endmodule

// File: rtl/dmf_unit_chk.sv
module dmf_unit_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         op_valid,
    input logic [2:0]   op_sel,
    input logic         wide_mode,
    input logic         ov_enable,
    input logic         flag_wr,
    input logic [4:0]   flag_wdata,
    input logic [W-1:0] src_b,
    input logic [W-1:0] result,
    input logic [4:0]   flags
);

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> flags == 5'd0);

    a_r10_write_loads: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> flags == $past(flag_wdata));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!flag_wr && (!op_valid || op_sel == 3'd7)) |=> flags == $past(flags));

    a_r8_so_sticky: assert property (@(posedge clk) disable iff (rst)
        (!flag_wr && flags[4]) |=> flags[4]);

    a_r7_ov_hold: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !flag_wr && !ov_enable) |=> flags[4:2] == $past(flags[4:2]));

    a_r2_narrow_carry_equal: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !flag_wr && !wide_mode && op_sel <= 3'd3) |=> flags[1] == flags[0]);

    a_r9_carry_untouched: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !flag_wr && op_sel >= 3'd4) |=> flags[1:0] == $past(flags[1:0]));

    a_r6_div_by_zero: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd6 && src_b == '0) |-> result == '0);

endmodule

bind dmf_unit dmf_unit_chk #(.W(W)) u_chk (.*);

// File: tb/dmf_unit_tb.sv
`timescale 1ns/1ps
module dmf_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic        wide_mode = 1'b1;
    logic        dw_size = 1'b1;
    logic        ov_enable = 1'b0;
    logic        carry_in = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        flag_wr = 1'b0;
    logic [4:0]  flag_wdata = '0;
    logic [63:0] result;
    logic [4:0]  flags;

    int n_tot  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dmf_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .wide_mode(wide_mode), .dw_size(dw_size), .ov_enable(ov_enable),
        .carry_in(carry_in), .src_a(src_a), .src_b(src_b),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .result(result), .flags(flags)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] opv(input int i);
        case (i)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'h0000_0000_7fff_ffff;
            3: return 64'h0000_0000_8000_0000;
            4: return 64'h0000_0000_ffff_ffff;
            5: return 64'h7fff_ffff_ffff_ffff;
            6: return 64'h8000_0000_0000_0000;
            7: return 64'hffff_ffff_ffff_ffff;
            8: return 64'h0000_0001_0000_0000;
            9: return 64'h1234_5678_9abc_def0;
            10: return 64'hffff_fffe_8000_0000;
            default: return 64'hffff_ffff_ffff_fffe;
        endcase
    endfunction

    task automatic run_vec(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                           input logic wm, input logic dw, input logic oe, input logic ci,
                           input logic [4:0] pre);
        logic [63:0] x, er, pw;
        logic [64:0] full;
        logic [32:0] lo;
        logic signed [65:0] s66;
        logic signed [33:0] s34;
        logic [127:0] p128;
        logic c64, c32, o64, o32, ovw, ovl, cb;
        logic [4:0] ef;
        longint qa, qb, pl;
        int wa, wb, wq;
        string rtag, otag;

        x    = (op >= 3'd2) ? ~a : a;
        cb   = op[0] ? ci : op[1];
        full = {1'b0, x} + {1'b0, b} + {64'd0, cb};
        lo   = {1'b0, x[31:0]} + {1'b0, b[31:0]} + {32'd0, cb};
        c64  = full[64];
        c32  = lo[32];
        s66  = $signed({x[63], x[63], x}) + $signed({b[63], b[63], b}) + $signed({65'd0, cb});
        s34  = $signed({x[31], x[31], x[31:0]}) + $signed({b[31], b[31], b[31:0]}) + $signed({33'd0, cb});
        o64  = (s66[65:63] != 3'b000) && (s66[65:63] != 3'b111);
        o32  = (s34[33:31] != 3'b000) && (s34[33:31] != 3'b111);
        ovw  = 1'b0;
        ovl  = 1'b0;
        er   = '0;
        case (op)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                er = full[63:0]; ovw = wm ? o64 : o32; ovl = o32; rtag = "R1"; otag = "R3";
            end
            3'd4: begin
                er = 64'd0 - a;
                ovw = wm ? (a == 64'h8000_0000_0000_0000) : (a[31:0] == 32'h8000_0000);
                ovl = ovw; rtag = "R4"; otag = "R4";
            end
            3'd5: begin
                if (dw) begin
                    p128 = {{64{a[63]}}, a} * {{64{b[63]}}, b};
                    er = p128[63:0];
                    ovw = p128 != {{64{p128[63]}}, p128[63:0]};
                end else begin
                    pl = longint'(int'(a[31:0])) * longint'(int'(b[31:0]));
                    pw = pl;
                    er = pw;
                    ovw = (pl > 64'sd2147483647) || (pl < -64'sd2147483648);
                end
                ovl = ovw; rtag = "R5"; otag = "R5";
            end
            3'd6: begin
                if (dw) begin
                    qa = a; qb = b;
                    ovw = (qb == 0) || ((a == 64'h8000_0000_0000_0000) && (qb == -1));
                    er = ovw ? 64'd0 : 64'(qa / qb);
                end else begin
                    wa = a[31:0]; wb = b[31:0];
                    ovw = (wb == 0) || ((a[31:0] == 32'h8000_0000) && (wb == -1));
                    wq = ovw ? 0 : wa / wb;
                    er = 64'(longint'(wq));
                end
                ovl = ovw; rtag = "R6"; otag = "R6";
            end
            default: begin
                er = '0; rtag = "R9"; otag = "R9";
            end
        endcase
        ef = pre;
        if (op <= 3'd3) begin
            ef[1] = wm ? c64 : c32;
            ef[0] = c32;
        end
        if (op != 3'd7 && oe) begin
            ef[3] = ovw;
            ef[2] = ovl;
            ef[4] = pre[4] | ovw;
        end
        if (!oe) otag = "R7";

        @(negedge clk);
        flag_wr = 1'b1; flag_wdata = pre; op_valid = 1'b0;
        @(negedge clk);
        flag_wr = 1'b0; op_valid = 1'b1; op_sel = op; src_a = a; src_b = b;
        wide_mode = wm; dw_size = dw; ov_enable = oe; carry_in = ci;
        #1;
        chk(result == er, rtag, result, er);
        chk(flags == pre, "R11", {59'd0, flags}, {59'd0, pre});
        @(negedge clk);
        op_valid = 1'b0;
        chk(flags[1:0] == ef[1:0], (op <= 3'd3) ? "R2" : "R9", {62'd0, flags[1:0]}, {62'd0, ef[1:0]});
        chk(flags[3:2] == ef[3:2], otag, {62'd0, flags[3:2]}, {62'd0, ef[3:2]});
        chk(flags[4] == ef[4], oe ? "R8" : "R7", {63'd0, flags[4]}, {63'd0, ef[4]});
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    endtask

    initial begin
        #(4 * 195000);
        if (!done) begin
            n_tot++; n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int vec;
        vec = 0;
        repeat (3) @(negedge clk);
        chk(flags == 5'd0, "R10", {59'd0, flags}, 64'd0);
        rst = 1'b0;

        // R10: flag write wins over a simultaneous operation
        @(negedge clk);
        flag_wr = 1'b1; flag_wdata = 5'b10101; op_valid = 1'b1; op_sel = 3'd0;
        src_a = 64'hffff_ffff_ffff_ffff; src_b = 64'd1; ov_enable = 1'b1;
        @(negedge clk);
        flag_wr = 1'b0; op_valid = 1'b0;
        chk(flags == 5'b10101, "R10", {59'd0, flags}, 64'h15);

        // R9: idle cycles with changing inputs leave the flags alone
        src_a = 64'h8000_0000_0000_0000; src_b = 64'h8000_0000_0000_0000;
        repeat (2) @(negedge clk);
        chk(flags == 5'b10101, "R9", {59'd0, flags}, 64'h15);

        // R8: SO survives a later clean operation
        flag_wr = 1'b1; flag_wdata = 5'd0;
        @(negedge clk);
        flag_wr = 1'b0; op_valid = 1'b1; op_sel = 3'd0; wide_mode = 1'b1;
        src_a = 64'h7fff_ffff_ffff_ffff; src_b = 64'd1; ov_enable = 1'b1;
        @(negedge clk);
        src_a = 64'd3; src_b = 64'd4;
        @(negedge clk);
        op_valid = 1'b0;
        chk(flags[4:3] == 2'b10, "R8", {62'd0, flags[4:3]}, 64'h2);

        // R10: reset clears a nonzero flag file
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(flags == 5'd0, "R10", {59'd0, flags}, 64'd0);

        for (int op = 0; op < 8; op++)
            for (int ia = 0; ia < 12; ia++)
                for (int ib = 0; ib < 12; ib++)
                    for (int m = 0; m < 8; m++) begin
                        vec++;
                        run_vec(3'(op), opv(ia), opv(ib), m[0], m[1], m[2],
                                vec[0] ^ vec[3], 5'((vec * 7) % 32));
                    end

        done = 1;
        summary();
        $finish;
    end

endmodule